// File: doc/BRIEF.md
# Embedded Timer Unit with Escalating Watchdog

This block gives an embedded core three timers that share one tick-enable input and one free-running time-base counter. The first is a down-counting interval timer that can reload itself. The second is a fixed-period timer. The third is a watchdog. Software must keep servicing the watchdog. If it does not, the watchdog escalates in three steps: a warning flag, then an interrupt, then a reset request.

A 32-bit control word selects the behaviour of all three timers. Each timer reports events through a 32-bit status word, and software clears those event bits by writing ones to them. The fixed timer and the watchdog have power-of-two periods, each chosen by a 2-bit code. Both periods are aligned to the shared time base. The block drives three interrupt lines and a reset request with a 2-bit type. Whatever acts on that reset request sits outside the block.

Top module: `timer_watchdog_unit`

## Requirements
- R1: Reset clears the control word, the status word, the interval count and the watchdog stage. After reset all interrupts, `rstReq` and `rstType` are 0.
- R2: Control bits 31:30 (code s) select a watchdog period of 2^(WDT_BASE+s·TAP_STEP) ticks, which is 2^17, 2^21, 2^25 or 2^29 by default. An expiry occurs on the tick at which the low bits of the time base covering that period are all ones.
- R3: At a watchdog expiry the block looks at status bits 31:30. If they are 00 or 01, it sets bit 31. If they are 10, it sets bit 30. `wdtIrq` equals status bit 30 AND control bit 27.
- R4: At a watchdog expiry with status bits 31:30 equal to 11, control bits 29:28 are copied into status bits 29:28. `rstType` shows status bits 29:28. `rstReq` is high when the watchdog has reached this final stage and the type is nonzero (1 core, 2 chip, 3 system). From then on the watchdog ignores further expiries until the block is reset.
- R5: Control bits 25:24 (code f) select a fixed timer period of 2^(FIT_BASE+f·TAP_STEP) ticks, which is 2^9, 2^13, 2^17 or 2^21 by default. Each expiry sets status bit 26. `fitIrq` equals status bit 26 AND control bit 23.
- R6: Writing the interval register with a value greater than 1 stores it as the reload value and loads it as the count. Writing 0 or 1 leaves the count at 0, which means stopped. `pitCount` shows the remaining count. The count falls by one per tick only while control bit 26 is set.
- R7: A tick that finds a count of 1 is an interval expiry and sets status bit 27. The count then reloads if control bit 22 is set, and goes to 0 if it is not. `pitIrq` equals status bit 27 AND control bit 26.
- R8: A clear write removes status bits 31, 30, 27 and 26 wherever the write data has ones. It leaves every other status bit unchanged. An event in the same cycle as a clear of its bit wins, so the bit ends up set.
- R9: While `tickEn` is low, the time base, the interval count and the status word do not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Time-base tick qualifier |
| ctrlWrEn | input | 1 | Write strobe for the control word |
| ctrlWrData | input | 32 | New control word |
| statClrEn | input | 1 | Write-one-to-clear strobe for the status word |
| statClrData | input | 32 | Bits to clear |
| pitWrEn | input | 1 | Write strobe for the interval register |
| pitWrData | input | PIT_W | Interval reload value |
| ctrlOut | output | 32 | Current control word |
| statOut | output | 32 | Current status word |
| pitCount | output | PIT_W | Remaining interval count |
| pitIrq | output | 1 | Interval timer interrupt |
| fitIrq | output | 1 | Fixed timer interrupt |
| wdtIrq | output | 1 | Watchdog interrupt |
| rstReq | output | 1 | Watchdog reset request |
| rstType | output | 2 | Requested reset type |

## Verification
Each piece of internal state shows up at a port. A time base that is off by even one tick moves a fixed-timer or watchdog flag into a different cycle of `statOut`. The bench model compares every clock, so that error is caught on the first expiry. A wrong watchdog stage appears as a status bit 30 or a reset request that arrives one period too early or too late. A wrong interval count or reload value appears on `pitCount` in the very next clock.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int CtlWdtSelLo  = 30;
  localparam int CtlRstTypeLo = 28;
  localparam int CtlWdtIe     = 27;
  localparam int CtlPitEn     = 26;
  localparam int CtlFitSelLo  = 24;
  localparam int CtlFitIe     = 23;
  localparam int CtlPitAuto   = 22;

  localparam int StWdtFirst   = 31;
  localparam int StWdtSecond  = 30;
  localparam int StRstLo      = 28;
  localparam int StPit        = 27;
  localparam int StFit        = 26;

  localparam logic [31:0] W1cMask = 32'hCC00_0000;

  typedef struct packed {
    logic       tick;
    logic       pitLoad;
    logic       pitRun;
    logic       pitAuto;
    logic [1:0] fitSel;
    logic [1:0] wdtSel;
  } tmrStrobe_t;

  typedef struct packed {
    logic fitExp;
    logic wdtExp;
    logic pitExp;
  } tmrEvent_t;
endpackage

// File: rtl/timer_datapath.sv
module timer_datapath
  import timer_pkg::*;
#(
  parameter int PIT_W    = 32,
  parameter int FIT_BASE = 9,
  parameter int WDT_BASE = 17,
  parameter int TAP_STEP = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmrStrobe_t       strobe,
  input  logic [PIT_W-1:0] pitWrData,
  output logic [PIT_W-1:0] pitCount,
  output tmrEvent_t        events
);
  localparam int FitTop = FIT_BASE + 3 * TAP_STEP;
  localparam int WdtTop = WDT_BASE + 3 * TAP_STEP;
  localparam int TbW    = (FitTop > WdtTop) ? FitTop : WdtTop;

  function automatic logic [TbW-1:0] tapMask(input int n);
    logic [TbW-1:0] m;
    m = '0;
    for (int i = 0; i < TbW; i++) begin
      if (i < n) m[i] = 1'b1;
    end
    return m;
  endfunction

  logic [TbW-1:0]   timeBase;
  logic [TbW-1:0]   fitMask [4];
  logic [TbW-1:0]   wdtMask [4];
  logic [PIT_W-1:0] pitReload;
  logic             fitHit, wdtHit;

  for (genvar g = 0; g < 4; g++) begin : g_tap
    assign fitMask[g] = tapMask(FIT_BASE + g * TAP_STEP);
    assign wdtMask[g] = tapMask(WDT_BASE + g * TAP_STEP);
  end

  assign fitHit = &(timeBase | ~fitMask[strobe.fitSel]);
  assign wdtHit = &(timeBase | ~wdtMask[strobe.wdtSel]);

  always_comb begin
    events.fitExp = strobe.tick & fitHit;
    events.wdtExp = strobe.tick & wdtHit;
    events.pitExp = !strobe.pitLoad && strobe.pitRun && (pitCount == PIT_W'(1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      timeBase <= '0;
    end else if (strobe.tick) begin
      timeBase <= timeBase + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pitCount  <= '0;
      pitReload <= '0;
    end else if (strobe.pitLoad) begin
      pitReload <= pitWrData;
      pitCount  <= (pitWrData > PIT_W'(1)) ? pitWrData : '0;
    end else if (strobe.pitRun && pitCount != '0) begin
      if (pitCount == PIT_W'(1)) pitCount <= strobe.pitAuto ? pitReload : '0;
      else                       pitCount <= pitCount - 1'b1;
    end
  end

  // R9: without a step or a load the remaining count must hold
  a_r9_count_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.pitRun && !strobe.pitLoad) |=> $stable(pitCount));

  // R6: a write of 0 or 1 leaves the interval timer stopped
  a_r6_small_load_stops: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.pitLoad && pitWrData <= PIT_W'(1)) |=> (pitCount == '0));
endmodule

// File: rtl/timer_ctrl.sv
module timer_ctrl
  import timer_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        tickEn,
  input  logic        ctrlWrEn,
  input  logic [31:0] ctrlWrData,
  input  logic        statClrEn,
  input  logic [31:0] statClrData,
  input  logic        pitWrEn,
  input  tmrEvent_t   events,
  output tmrStrobe_t  strobe,
  output logic [31:0] ctrlReg,
  output logic [31:0] statReg,
  output logic        pitIrq,
  output logic        fitIrq,
  output logic        wdtIrq,
  output logic        rstReq,
  output logic [1:0]  rstType
);
  logic [31:0] statNext;
  logic        wdtDone, doneNext;

  always_comb begin
    strobe.tick    = tickEn;
    strobe.pitLoad = pitWrEn;
    strobe.pitRun  = tickEn & ctrlReg[CtlPitEn];
    strobe.pitAuto = ctrlReg[CtlPitAuto];
    strobe.fitSel  = ctrlReg[CtlFitSelLo +: 2];
    strobe.wdtSel  = ctrlReg[CtlWdtSelLo +: 2];
  end

  always_comb begin
    statNext = statReg;
    doneNext = wdtDone;
    if (statClrEn) statNext = statNext & ~(statClrData & W1cMask);
    if (events.fitExp) statNext[StFit] = 1'b1;
    if (events.pitExp) statNext[StPit] = 1'b1;
    if (events.wdtExp && !wdtDone) begin
      unique case (statReg[StWdtSecond +: 2])
        2'b10: statNext[StWdtSecond] = 1'b1;
        2'b11: begin
          statNext[StRstLo +: 2] = ctrlReg[CtlRstTypeLo +: 2];
          doneNext               = 1'b1;
        end
        default: statNext[StWdtFirst] = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg <= '0;
      statReg <= '0;
      wdtDone <= 1'b0;
    end else begin
      if (ctrlWrEn) ctrlReg <= ctrlWrData;
      statReg <= statNext;
      wdtDone <= doneNext;
    end
  end

  assign pitIrq  = statReg[StPit] & ctrlReg[CtlPitEn];
  assign fitIrq  = statReg[StFit] & ctrlReg[CtlFitIe];
  assign wdtIrq  = statReg[StWdtSecond] & ctrlReg[CtlWdtIe];
  assign rstType = statReg[StRstLo +: 2];
  assign rstReq  = wdtDone & (|rstType);

  // R4: once issued the reset request and its type are held
  a_r4_req_sticky: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |=> (rstReq && $stable(rstType)));

  // R3: the second stage can only follow a set first-stage flag
  a_r3_stage_order: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statReg[StWdtSecond]) |-> $past(statReg[StWdtFirst]));

  // R7: an interval expiry leaves its status bit set
  a_r7_pit_flag: assert property (@(posedge clk) disable iff (!rstN)
    events.pitExp |=> statReg[StPit]);

  // R5: a fixed-timer expiry leaves its status bit set
  a_r5_fit_flag: assert property (@(posedge clk) disable iff (!rstN)
    events.fitExp |=> statReg[StFit]);
endmodule

// File: rtl/timer_watchdog_unit.sv
module timer_watchdog_unit
  import timer_pkg::*;
#(
  parameter int PIT_W    = 32,
  parameter int FIT_BASE = 9,
  parameter int WDT_BASE = 17,
  parameter int TAP_STEP = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic             ctrlWrEn,
  input  logic [31:0]      ctrlWrData,
  input  logic             statClrEn,
  input  logic [31:0]      statClrData,
  input  logic             pitWrEn,
  input  logic [PIT_W-1:0] pitWrData,
  output logic [31:0]      ctrlOut,
  output logic [31:0]      statOut,
  output logic [PIT_W-1:0] pitCount,
  output logic             pitIrq,
  output logic             fitIrq,
  output logic             wdtIrq,
  output logic             rstReq,
  output logic [1:0]       rstType
);
  tmrStrobe_t strobe;
  tmrEvent_t  events;

  timer_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn),
    .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData),
    .statClrEn(statClrEn), .statClrData(statClrData),
    .pitWrEn(pitWrEn), .events(events), .strobe(strobe),
    .ctrlReg(ctrlOut), .statReg(statOut),
    .pitIrq(pitIrq), .fitIrq(fitIrq), .wdtIrq(wdtIrq),
    .rstReq(rstReq), .rstType(rstType)
  );

  timer_datapath #(
    .PIT_W(PIT_W), .FIT_BASE(FIT_BASE), .WDT_BASE(WDT_BASE), .TAP_STEP(TAP_STEP)
  ) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .pitWrData(pitWrData), .pitCount(pitCount), .events(events)
  );
endmodule

// File: tb/test_timer_watchdog_unit.sv
module test_timer_watchdog_unit;
  localparam int FB = 3, WB = 5, ST = 1;

  logic        clk = 1'b0, rstN = 1'b0, tickEn = 1'b0;
  logic        ctrlWrEn = 1'b0, statClrEn = 1'b0, pitWrEn = 1'b0;
  logic [31:0] ctrlWrData = '0, statClrData = '0, pitWrData = '0;
  logic [31:0] ctrlOut, statOut, pitCount;
  logic        pitIrq, fitIrq, wdtIrq, rstReq;
  logic [1:0]  rstType;

  int nChk = 0, nFail = 0, cyc = 0;

  timer_watchdog_unit #(.PIT_W(32), .FIT_BASE(FB), .WDT_BASE(WB), .TAP_STEP(ST)) i_timer_watchdog_unit (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData),
    .statClrEn(statClrEn), .statClrData(statClrData), .pitWrEn(pitWrEn), .pitWrData(pitWrData),
    .ctrlOut(ctrlOut), .statOut(statOut), .pitCount(pitCount), .pitIrq(pitIrq),
    .fitIrq(fitIrq), .wdtIrq(wdtIrq), .rstReq(rstReq), .rstType(rstType)
  );

  always #2 clk = ~clk;

  // behavioural reference model
  longint      mTb;
  logic [31:0] mCtrl, mStat, mPit, mRel;
  bit          mDone;

  always @(posedge clk) begin
    if (!rstN) begin
      mTb = 0; mCtrl = 0; mStat = 0; mPit = 0; mRel = 0; mDone = 0;
    end else begin
      longint fp, wp;
      bit fitE, wdtE, pitE;
      logic [31:0] ns;
      fp   = longint'(1) << (FB + ST * int'(mCtrl[25:24]));
      wp   = longint'(1) << (WB + ST * int'(mCtrl[31:30]));
      fitE = tickEn && ((mTb % fp) == fp - 1);
      wdtE = tickEn && !mDone && ((mTb % wp) == wp - 1);
      pitE = !pitWrEn && tickEn && mCtrl[26] && (mPit == 1);
      ns = mStat;
      if (statClrEn) ns = ns & ~(statClrData & 32'hCC00_0000);
      if (fitE) ns[26] = 1'b1;
      if (pitE) ns[27] = 1'b1;
      if (wdtE) begin
        if (mStat[31:30] == 2'b10) ns[30] = 1'b1;
        else if (mStat[31:30] == 2'b11) begin ns[29:28] = mCtrl[29:28]; mDone = 1; end
        else ns[31] = 1'b1;
      end
      if (pitWrEn) begin
        mRel = pitWrData;
        mPit = (pitWrData > 1) ? pitWrData : 0;
      end else if (tickEn && mCtrl[26] && mPit != 0) begin
        mPit = (mPit == 1) ? (mCtrl[22] ? mRel : 0) : mPit - 1;
      end
      if (ctrlWrEn) mCtrl = ctrlWrData;
      if (tickEn) mTb = mTb + 1;
      mStat = ns;
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nChk++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  always @(negedge clk) begin
    chk("R1 R2 R3 watchdog stages", {30'd0, statOut[31:30]}, {30'd0, mStat[31:30]});
    chk("R4 reset type", {30'd0, statOut[29:28]}, {30'd0, mStat[29:28]});
    chk("R4 reset request", {31'd0, rstReq}, {31'd0, mDone && (mStat[29:28] != 0)});
    chk("R7 interval flag", {31'd0, statOut[27]}, {31'd0, mStat[27]});
    chk("R5 fixed flag", {31'd0, statOut[26]}, {31'd0, mStat[26]});
    chk("R8 other status bits", {6'd0, statOut[25:0]}, {6'd0, mStat[25:0]});
    chk("R6 interval count", pitCount, mPit);
    chk("R7 interval irq", {31'd0, pitIrq}, {31'd0, mStat[27] & mCtrl[26]});
    chk("R5 fixed irq", {31'd0, fitIrq}, {31'd0, mStat[26] & mCtrl[23]});
    chk("R3 watchdog irq", {31'd0, wdtIrq}, {31'd0, mStat[30] & mCtrl[27]});
    chk("R1 control word", ctrlOut, mCtrl);
  end

  task automatic step(); @(posedge clk); #1; endtask
  task automatic idle(input int n); repeat (n) step(); endtask
  task automatic wrCtrl(input logic [31:0] v);
    ctrlWrEn = 1'b1; ctrlWrData = v; step(); ctrlWrEn = 1'b0;
  endtask
  task automatic wrPit(input logic [31:0] v);
    pitWrEn = 1'b1; pitWrData = v; step(); pitWrEn = 1'b0;
  endtask
  task automatic clrStat(input logic [31:0] v);
    statClrEn = 1'b1; statClrData = v; step(); statClrEn = 1'b0;
  endtask
  task automatic doReset();
    rstN = 1'b0; idle(3); rstN = 1'b1;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      nChk++; nFail++;
      $display("FAIL watchdog: run hung, got cycle %0d expected below 100000", cyc);
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  initial begin
    logic [31:0] held, heldStat;
    idle(3);
    chk("R1 status after reset", statOut, 32'h0);
    chk("R1 count after reset", pitCount, 32'h0);
    chk("R1 request after reset", {30'd0, rstType}, {30'd0, 2'b00});
    rstN = 1'b1;
    tickEn = 1'b1;
    // wdt sel 0, type 2, wdt ie, pit en, fit sel 1, fit ie, auto reload
    wrCtrl(32'h2DC0_0000);
    wrPit(32'd5);
    chk("R6 loaded count", pitCount, 32'd5);
    for (int i = 0; i < 10; i++) begin
      idle(20);
      clrStat(32'h8000_0000);
      if (i % 3 == 0) clrStat(32'h0C00_0000);
    end
    chk("R3 serviced watchdog stays at first stage", {31'd0, statOut[30]}, 32'd0);
    // R9: no ticks
    tickEn = 1'b0;
    held = pitCount; heldStat = statOut;
    idle(30);
    chk("R9 count frozen", pitCount, held);
    chk("R9 status frozen", statOut, heldStat);
    for (int i = 0; i < 100; i++) begin
      tickEn = i[0]; step();
      if (i % 25 == 0) clrStat(32'h8000_0000);
    end
    tickEn = 1'b1;
    wrPit(32'd1);
    chk("R6 write of one stops", pitCount, 32'd0);
    wrPit(32'd0);
    chk("R6 write of zero stops", pitCount, 32'd0);
    // no auto reload
    wrCtrl(32'h2D80_0000);
    clrStat(32'h0800_0000);
    clrStat(32'h8000_0000);
    wrPit(32'd3);
    idle(6);
    chk("R7 one-shot ends at zero", pitCount, 32'd0);
    chk("R7 one-shot flag", {31'd0, statOut[27]}, 32'd1);
    chk("R7 one-shot irq", {31'd0, pitIrq}, 32'd1);
    // let the watchdog escalate
    idle(200);
    chk("R4 reset request raised", {31'd0, rstReq}, 32'd1);
    chk("R4 chip type", {30'd0, rstType}, 32'd2);
    chk("R3 second stage irq", {31'd0, wdtIrq}, 32'd1);
    clrStat(32'hFFFF_FFFF);
    chk("R8 type bits not clearable", {30'd0, statOut[29:28]}, 32'd2);
    idle(150);
    chk("R4 watchdog idle after request", {30'd0, statOut[31:30]}, 32'd0);
    chk("R4 request held", {31'd0, rstReq}, 32'd1);
    // second run: type 0, wdt sel 1, fit sel 3
    doReset();
    wrCtrl(32'h4B80_0000);
    wrPit(32'd7);
    idle(400);
    chk("R4 type zero gives no request", {31'd0, rstReq}, 32'd0);
    chk("R4 type zero copied", {30'd0, statOut[29:28]}, 32'd0);
    chk("R6 disabled timer holds", pitCount, 32'd7);
    wrCtrl(32'h0C40_0000);
    wrPit(32'd4);
    idle(40);
    clrStat(32'h0400_0000);
    idle(10);
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule